// File: doc/BRIEF.md
# Divided Tick Root Slice

This block is one root of a clock-generation tree, modelled entirely as clock-enable strobes inside a single system clock domain. Eight source tick strobes come in. A 3-bit selector picks one of them. Each selected tick then advances a pre-divider, and every pre-divider wrap in turn advances a post-divider. When both counters wrap together, the slice emits a one-cycle output tick, but only while its enable bit is set. Source 0 is meant to carry the fixed 24 MHz reference ticks.

Software programs the slice through one 32-bit control word. The word has three write offsets. Offset 0 writes the whole word. Offset 4 ORs the written ones into the word. Offset 8 clears the bits that are ones in the written data. A single write can carry a new selector and both divider values. The new values are staged and reach the active divider only at a boundary where a full output period has just completed, or at once while the slice is disabled. This way a reconfiguration never produces a shortened period.

Top module: `tick_root_slice`

## Requirements
- R1: A write at byte offset 0 replaces the control word. Reads always return the staged word. The word holds the selector in bits 2:0, the pre-divider in bits 10:8, the post-divider in bits 21:16 and the enable in bit 28; all other bits read as 0.
- R2: A write at offset 4 sets every defined bit that is 1 in the written data and leaves the others unchanged.
- R3: A write at offset 8 clears every bit that is 1 in the written data and leaves the others unchanged.
- R4: A write at any other offset (for example 12) leaves the control word and the output unchanged.
- R5: After reset the control word reads 0 and the output tick is low.
- R6: Only the source whose index equals the active selector advances the dividers; ticks on the other sources have no effect.
- R7: With pre-divider field P and post-divider field Q, one output tick is produced per (P+1)*(Q+1) selected source ticks. It is high for exactly one cycle, in the cycle after the source tick that completes the period.
- R8: With both divider fields at 0, every selected source tick appears on the output one cycle later.
- R9: While the enable bit is 0 no output tick is produced and both divider counters are held at zero, so after re-enabling, the first output tick comes after a full period.
- R10: While enabled, a new selector and divider setting takes effect only in the cycle after an output tick has been produced; while disabled, it takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | 8 | Source tick strobes, one per selectable source |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset of the write (0 word, 4 set, 8 clear) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Staged control word |
| tickOut | output | 1 | Divided output tick strobe |

## Verification
Sources are driven with distinct periods (source i ticks every i+1 cycles), so a wrong selector shows up as a wrong output rate. Pass-through with an every-cycle source distinguishes an extra pipeline stage from a correct one-cycle latency. Non-trivial pre and post values (2x3 and 4x6) expose swapped or miscounted cascade stages. Reconfiguring mid-period, toggling enable through the set and clear aliases, and writing an unused offset separate staged from immediate application and show whether the counters are cleared while disabled.

// File: rtl/trs_pkg.sv
package trs_pkg;
  parameter int unsigned NUM_SRC  = 8;
  parameter int unsigned SEL_W    = $clog2(NUM_SRC);
  parameter int unsigned PRE_W    = 3;
  parameter int unsigned POST_W   = 6;
  parameter int unsigned REG_W    = 32;
  parameter int unsigned ADDR_W   = 4;

  parameter int unsigned SEL_LSB  = 0;
  parameter int unsigned PRE_LSB  = 8;
  parameter int unsigned POST_LSB = 16;
  parameter int unsigned EN_BIT   = 28;

  parameter int unsigned OFF_WORD = 0;
  parameter int unsigned OFF_SET  = 4;
  parameter int unsigned OFF_CLR  = 8;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } rootCfg_t;

  typedef struct packed {
    logic     enable;
    rootCfg_t cfg;
  } ctrlStrobe_t;

  function automatic logic [REG_W-1:0] fieldMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(SEL_W); i++)  m[SEL_LSB + i]  = 1'b1;
    for (int i = 0; i < int'(PRE_W); i++)  m[PRE_LSB + i]  = 1'b1;
    for (int i = 0; i < int'(POST_W); i++) m[POST_LSB + i] = 1'b1;
    m[EN_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] FIELD_MASK = fieldMask();
endpackage

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              periodDone,
  output logic [REG_W-1:0]  regRdData,
  output ctrlStrobe_t       ctrlOut
);
  logic [REG_W-1:0] stagedQ;
  logic [REG_W-1:0] stagedNext;
  rootCfg_t         activeQ;
  rootCfg_t         stagedCfg;
  logic             enabled;
  logic             applyNow;

  always_comb begin
    stagedNext = stagedQ;
    if (regWr) begin
      if (regAddr == ADDR_W'(OFF_WORD))
        stagedNext = regWrData & FIELD_MASK;
      else if (regAddr == ADDR_W'(OFF_SET))
        stagedNext = (stagedQ | regWrData) & FIELD_MASK;
      else if (regAddr == ADDR_W'(OFF_CLR))
        stagedNext = stagedQ & ~regWrData;
    end
  end

  assign stagedCfg.sel  = stagedQ[SEL_LSB +: SEL_W];
  assign stagedCfg.pre  = stagedQ[PRE_LSB +: PRE_W];
  assign stagedCfg.post = stagedQ[POST_LSB +: POST_W];
  assign enabled        = stagedQ[EN_BIT];
  assign applyNow       = !enabled || periodDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedQ <= '0;
      activeQ <= '0;
    end else begin
      stagedQ <= stagedNext;
      if (applyNow) activeQ <= stagedCfg;
    end
  end

  assign regRdData      = stagedQ;
  assign ctrlOut.enable = enabled;
  assign ctrlOut.cfg    = activeQ;
endmodule

// File: rtl/trs_datapath.sv
module trs_datapath
  import trs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  ctrlStrobe_t        ctrlIn,
  output logic               periodDone,
  output logic               tickOut
);
  logic [NUM_SRC-1:0] srcHit;
  logic               tickSel;
  logic [PRE_W-1:0]   preCntQ;
  logic [POST_W-1:0]  postCntQ;
  logic               preWrap;
  logic               postWrap;
  logic               tickQ;

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_srcSel
    assign srcHit[g] = srcTick[g] && (ctrlIn.cfg.sel == SEL_W'(g));
  end
  assign tickSel = |srcHit;

  assign preWrap    = tickSel && (preCntQ == ctrlIn.cfg.pre);
  assign postWrap   = preWrap && (postCntQ == ctrlIn.cfg.post);
  assign periodDone = ctrlIn.enable && postWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCntQ  <= '0;
      postCntQ <= '0;
      tickQ    <= 1'b0;
    end else begin
      tickQ <= periodDone;
      if (!ctrlIn.enable) begin
        preCntQ  <= '0;
        postCntQ <= '0;
      end else if (tickSel) begin
        if (preWrap) begin
          preCntQ <= '0;
          if (postWrap) postCntQ <= '0;
          else          postCntQ <= postCntQ + 1'b1;
        end else begin
          preCntQ <= preCntQ + 1'b1;
        end
      end
    end
  end

  assign tickOut = tickQ;
endmodule

// File: rtl/tick_root_slice.sv
module tick_root_slice
  import trs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               tickOut
);
  ctrlStrobe_t ctrlBus;
  logic        periodDone;

  trs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .periodDone (periodDone),
    .regRdData  (regRdData),
    .ctrlOut    (ctrlBus)
  );

  trs_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcTick    (srcTick),
    .ctrlIn     (ctrlBus),
    .periodDone (periodDone),
    .tickOut    (tickOut)
  );
endmodule

// File: rtl/tick_root_checks.sv
module tick_root_checks
  import trs_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcTick,
  input logic               regWr,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [REG_W-1:0]   regWrData,
  input logic [REG_W-1:0]   regRdData,
  input logic               tickOut
);
  logic knownOffset;
  assign knownOffset = (regAddr == ADDR_W'(OFF_WORD)) || (regAddr == ADDR_W'(OFF_SET)) ||
                       (regAddr == ADDR_W'(OFF_CLR));

  p_plain_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(OFF_WORD)) |=> regRdData == ($past(regWrData) & FIELD_MASK));

  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(OFF_SET)) |=>
      regRdData == (($past(regRdData) | $past(regWrData)) & FIELD_MASK));

  p_clear_alias_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(OFF_CLR)) |=>
      regRdData == ($past(regRdData) & ~$past(regWrData)));

  p_bad_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !knownOffset) |=> $stable(regRdData));

  p_src_needed_r6: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(|srcTick));

  p_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(regRdData[EN_BIT]));
endmodule

bind tick_root_slice tick_root_checks u_chk (.*);

// File: tb/tb_tick_root_slice.sv
module tb_tick_root_slice;
  import trs_pkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] srcTick = '0;
  logic               regWr = 1'b0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic [REG_W-1:0]   regWrData = '0;
  logic [REG_W-1:0]   regRdData;
  logic               tickOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phaseTag = "R5";

  // reference model state
  logic [REG_W-1:0] mStaged = '0;
  int mSel = 0, mPre = 0, mPost = 0, mPreCnt = 0, mPostCnt = 0;
  logic mTick = 1'b0;

  always #10 clk = ~clk;

  tick_root_slice dut (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .tickOut(tickOut)
  );

  function automatic logic [REG_W-1:0] mkWord(bit en, int sel, int pre, int post);
    logic [REG_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W]   = SEL_W'(sel);
    w[PRE_LSB +: PRE_W]   = PRE_W'(pre);
    w[POST_LSB +: POST_W] = POST_W'(post);
    w[EN_BIT]             = en;
    return w;
  endfunction

  // behavioural reference, one step per rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mStaged = '0; mSel = 0; mPre = 0; mPost = 0;
      mPreCnt = 0; mPostCnt = 0; mTick = 1'b0;
    end else begin
      logic en, sel, wrap;
      logic [REG_W-1:0] old;
      old  = mStaged;
      en   = old[EN_BIT];
      sel  = srcTick[mSel];
      wrap = en && sel && (mPreCnt == mPre) && (mPostCnt == mPost);
      mTick = wrap;
      if (!en) begin
        mPreCnt = 0; mPostCnt = 0;
      end else if (sel) begin
        if (mPreCnt == mPre) begin
          mPreCnt = 0;
          if (mPostCnt == mPost) mPostCnt = 0; else mPostCnt++;
        end else mPreCnt++;
      end
      if (!en || wrap) begin
        mSel  = int'(old[SEL_LSB +: SEL_W]);
        mPre  = int'(old[PRE_LSB +: PRE_W]);
        mPost = int'(old[POST_LSB +: POST_W]);
      end
      if (regWr) begin
        if (regAddr == ADDR_W'(OFF_WORD))     mStaged = regWrData & FIELD_MASK;
        else if (regAddr == ADDR_W'(OFF_SET)) mStaged = (old | regWrData) & FIELD_MASK;
        else if (regAddr == ADDR_W'(OFF_CLR)) mStaged = old & ~regWrData;
      end
    end
  end

  // source generator: source i ticks every i+1 cycles
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < int'(NUM_SRC); i++) srcTick[i] <= rstN && ((cyc % (i + 1)) == 0);
  end

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (tickOut !== mTick) begin
        errors++;
        $display("FAIL %s tickOut got %0b expected %0b at cycle %0d", phaseTag, tickOut, mTick, cyc);
      end
      checks++;
      if (regRdData !== mStaged) begin
        errors++;
        $display("FAIL %s regRdData got %h expected %h at cycle %0d", phaseTag, regRdData, mStaged, cyc);
      end
    end
  end

  task automatic wrReg(input int off, input logic [REG_W-1:0] data);
    @(negedge clk);
    regWr = 1'b1; regAddr = ADDR_W'(off); regWrData = data;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic countTicks(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (tickOut) cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 word", int'(regRdData), 0);
    check("R5 tick", int'(tickOut), 0);
    rstN = 1'b1;
    idle(3);

    // R1: undefined bits read 0, then a real configuration
    phaseTag = "R1";
    wrReg(OFF_WORD, '1);
    check("R1 mask", int'(regRdData), int'(FIELD_MASK));
    wrReg(OFF_WORD, mkWord(1'b0, 0, 1, 2));
    idle(4);

    // R7: source 0 every cycle, divide by 2*3 = 6
    phaseTag = "R7";
    wrReg(OFF_SET, mkWord(1'b1, 0, 0, 0));
    idle(30);
    countTicks(60, cnt);
    check("R7 ticks in 60 cycles", cnt, 10);
    // R7: source 2 (every 3 cycles), divide by 4*6
    wrReg(OFF_WORD, mkWord(1'b1, 2, 3, 5));
    idle(400);

    // R8: pass-through of the every-cycle source
    phaseTag = "R8";
    wrReg(OFF_WORD, mkWord(1'b0, 0, 0, 0));
    wrReg(OFF_WORD, mkWord(1'b1, 0, 0, 0));
    idle(2);
    countTicks(20, cnt);
    check("R8 ticks in 20 cycles", cnt, 20);

    // R6: selector picks source 3 (every 4 cycles); others keep toggling
    phaseTag = "R6";
    wrReg(OFF_WORD, mkWord(1'b1, 3, 0, 0));
    idle(20);
    countTicks(40, cnt);
    check("R6 ticks from source 3", cnt, 10);

    // R2 / R3: set and clear aliases
    phaseTag = "R2";
    wrReg(OFF_SET, mkWord(1'b0, 0, 1, 1));
    idle(60);
    phaseTag = "R3";
    wrReg(OFF_CLR, mkWord(1'b0, 3, 0, 0));
    idle(40);

    // R9: disable via clear alias, then re-enable
    phaseTag = "R9";
    wrReg(OFF_CLR, mkWord(1'b1, 0, 0, 0));
    countTicks(40, cnt);
    check("R9 no ticks while disabled", cnt, 0);
    wrReg(OFF_SET, mkWord(1'b1, 0, 0, 0));
    idle(40);

    // R10: reconfigure mid-period while enabled
    phaseTag = "R10";
    wrReg(OFF_WORD, mkWord(1'b0, 0, 3, 5));
    wrReg(OFF_WORD, mkWord(1'b1, 0, 3, 5));
    idle(10);
    wrReg(OFF_WORD, mkWord(1'b1, 1, 0, 1));
    idle(100);
    wrReg(OFF_WORD, mkWord(1'b1, 0, 7, 63));
    idle(50);
    wrReg(OFF_WORD, mkWord(1'b1, 0, 1, 0));
    idle(600);

    // R4: unused offset is ignored
    phaseTag = "R4";
    wrReg(12, '1);
    idle(20);
    wrReg(2, '0);
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule